// File: doc/BRIEF.md
# Triggered Fractional Clock Divider

This block produces a clock-enable pulse train from a source clock. The division ratio has an integer part and a fractional part. Software programs a pending divider value over a simple register bus, then commits it by writing 1 to a trigger bit. The new ratio takes effect at the next output period boundary, so no output period is ever cut short or stretched by a change. An optional integer pre-divider sits ahead of the main stage. It has its own pending field and its own trigger bit.

The main stage uses a fractional accumulator. Every output period lasts either the floor or the ceiling of the programmed divisor, and the long-run average equals it exactly. All counting and every commit depend on a gate enable input. While it is low, the output is silent, the counters hold their values and trigger writes are ignored.

Top module: `frac_clk_div`

## Requirements
- R1: Register 0 holds the main field at bits [MAIN_SHIFT +: 12], with MAIN_SHIFT = 4 by default. Register 1 holds the pre-divider field at bits [3:0]. Reads return the last written field values, and every other bit reads 0.
- R2: A main field value F encodes a divisor of (F + 16) / 16. The low 4 bits of F are the fraction, and the implied +1 lands above them. Any 16 consecutive output periods therefore span exactly (F + 16) × (P + 1) source cycles, where P is the active pre-divider field.
- R3: With the pre-divider at 1, each gap between output pulses is either the floor or the ceiling of the divisor, in source cycles.
- R4: Register 2 holds the trigger bits: bit 0 for the main divider and bit 1 for the pre-divider. Writing 1 to a trigger bit while enabled makes it read 1. It reads 1 until the commit has been applied, then reads 0.
- R5: A main-divider commit is applied at the next output period boundary. The main trigger bit reads 0 in the same cycle in which that boundary's output pulse is high.
- R6: A trigger write while enable_i is low is ignored. The trigger bit stays 0, and the divisor in effect does not change.
- R7: While enable_i is low, clk_en_o stays 0 from the following cycle on, and the division state holds its value.
- R8: A pre-divider field value P divides the source by P + 1 ahead of the main stage. Its commit is applied at a pre-divider period boundary through trigger bit 1.
- R9: After reset all fields and trigger bits read 0. Once enabled, the block divides by 1, so clk_en_o is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Gate enable; counting and commits only while high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write register index (0 main, 1 pre, 2 trigger) |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Read register index |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| clk_en_o | output | 1 | Divided clock-enable pulse, one cycle wide per period |

## Verification
The main function is exercised with the following divisors:
- divide-by-1, a half-step fraction and an exact integer;
- 3.5 and an irregular fraction (3.3125);
- the largest integer, and the all-ones field (256.9375).

Comparing gap bounds with the exact span of 16 periods separates a wrong rounding of the fraction from a wrong offset of the +1. Pre-divider settings of 2 and 3 combined with integer and fractional main divisors show whether the two stages cascade multiplicatively. Directed runs commit while disabled and commit against a long period, which exposes commits applied mid-period or trigger bits that clear early.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  typedef enum logic [1:0] {
    REG_MAIN = 2'd0,
    REG_PRE  = 2'd1,
    REG_TRIG = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/frac_div_regs.sv
module frac_div_regs
  import frac_div_pkg::*;
#(
  parameter int FIELD_W       = 12,
  parameter int MAIN_SHIFT    = 4,
  parameter int PRE_W         = 4,
  parameter int PRE_SHIFT     = 0,
  parameter int MAIN_TRIG_BIT = 0,
  parameter int PRE_TRIG_BIT  = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [31:0]        wr_data_i,
  input  logic [1:0]         rd_addr_i,
  output logic [31:0]        rd_data_o,
  input  logic               main_done_i,
  input  logic               pre_done_i,
  output logic [FIELD_W-1:0] main_pend_o,
  output logic [PRE_W-1:0]   pre_pend_o,
  output logic               main_busy_o,
  output logic               pre_busy_o
);
  logic [FIELD_W-1:0] main_pend_q;
  logic [PRE_W-1:0]   pre_pend_q;
  logic main_busy_q, pre_busy_q;
  logic wr_main, wr_pre, wr_trig, main_set, pre_set;

  assign wr_main  = wr_en_i && (reg_sel_e'(wr_addr_i) == REG_MAIN);
  assign wr_pre   = wr_en_i && (reg_sel_e'(wr_addr_i) == REG_PRE);
  assign wr_trig  = wr_en_i && (reg_sel_e'(wr_addr_i) == REG_TRIG);
  // commits only land while the gate is open
  assign main_set = wr_trig && wr_data_i[MAIN_TRIG_BIT] && enable_i;
  assign pre_set  = wr_trig && wr_data_i[PRE_TRIG_BIT] && enable_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_pend_q <= '0;
      pre_pend_q  <= '0;
      main_busy_q <= 1'b0;
      pre_busy_q  <= 1'b0;
    end else begin
      if (wr_main) main_pend_q <= wr_data_i[MAIN_SHIFT +: FIELD_W];
      if (wr_pre)  pre_pend_q  <= wr_data_i[PRE_SHIFT +: PRE_W];
      if (main_set)         main_busy_q <= 1'b1;
      else if (main_done_i) main_busy_q <= 1'b0;
      if (pre_set)          pre_busy_q  <= 1'b1;
      else if (pre_done_i)  pre_busy_q  <= 1'b0;
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (reg_sel_e'(rd_addr_i))
      REG_MAIN: rd_data_o[MAIN_SHIFT +: FIELD_W] = main_pend_q;
      REG_PRE:  rd_data_o[PRE_SHIFT +: PRE_W]    = pre_pend_q;
      REG_TRIG: begin
        rd_data_o[MAIN_TRIG_BIT] = main_busy_q;
        rd_data_o[PRE_TRIG_BIT]  = pre_busy_q;
      end
      default:  rd_data_o = '0;
    endcase
  end

  assign main_pend_o = main_pend_q;
  assign pre_pend_o  = pre_pend_q;
  assign main_busy_o = main_busy_q;
  assign pre_busy_o  = pre_busy_q;
endmodule

// File: rtl/frac_pre_stage.sv
module frac_pre_stage #(
  parameter int PRE_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             load_i,
  input  logic [PRE_W-1:0] pend_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q, cur_q;

  assign tick_o = enable_i && (cnt_q == cur_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cur_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
      if (load_i) cur_q <= pend_i;
    end else if (enable_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/frac_acc_stage.sv
module frac_acc_stage #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      tick_i,
  input  logic                      load_i,
  input  logic [INT_W+FRAC_W-1:0]   pend_i,
  output logic                      hit_o,
  output logic [INT_W+FRAC_W-1:0]   cur_o
);
  localparam int FIELD_W = INT_W + FRAC_W;
  localparam int ACC_W   = FIELD_W + 1;
  localparam logic [ACC_W-1:0] ONE = ACC_W'(1) << FRAC_W;

  logic [FIELD_W-1:0] cur_q;
  logic [ACC_W-1:0]   acc_q, sum, span;

  // scaled divisor = field + 1.0
  assign span  = {1'b0, cur_q} + ONE;
  assign sum   = acc_q + ONE;
  assign hit_o = tick_i && (sum >= span);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cur_q <= '0;
    end else if (tick_i) begin
      acc_q <= hit_o ? (sum - span) : sum;
      if (hit_o && load_i) cur_q <= pend_i;
    end
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
  parameter int INT_W         = 8,
  parameter int FRAC_W        = 4,
  parameter int MAIN_SHIFT    = 4,
  parameter int PRE_W         = 4,
  parameter int PRE_SHIFT     = 0,
  parameter int MAIN_TRIG_BIT = 0,
  parameter int PRE_TRIG_BIT  = 1,
  parameter bit PRE_EN        = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        enable_i,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_addr_i,
  input  logic [31:0] wr_data_i,
  input  logic [1:0]  rd_addr_i,
  output logic [31:0] rd_data_o,
  output logic        clk_en_o
);
  localparam int FIELD_W = INT_W + FRAC_W;

  logic [FIELD_W-1:0] main_pend, main_cur;
  logic [PRE_W-1:0]   pre_pend;
  logic main_busy, pre_busy, pre_tick, main_hit, clk_en_q;

  frac_div_regs #(
    .FIELD_W(FIELD_W), .MAIN_SHIFT(MAIN_SHIFT), .PRE_W(PRE_W),
    .PRE_SHIFT(PRE_SHIFT), .MAIN_TRIG_BIT(MAIN_TRIG_BIT),
    .PRE_TRIG_BIT(PRE_TRIG_BIT)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .main_done_i(main_hit), .pre_done_i(pre_tick),
    .main_pend_o(main_pend), .pre_pend_o(pre_pend),
    .main_busy_o(main_busy), .pre_busy_o(pre_busy)
  );

  generate
    if (PRE_EN) begin : g_pre
      frac_pre_stage #(.PRE_W(PRE_W)) u_pre (
        .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i),
        .load_i(pre_busy), .pend_i(pre_pend), .tick_o(pre_tick)
      );
    end else begin : g_no_pre
      logic [PRE_W:0] unused_pre;
      assign unused_pre = {pre_busy, pre_pend};
      assign pre_tick   = enable_i;
    end
  endgenerate

  frac_acc_stage #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(pre_tick),
    .load_i(main_busy), .pend_i(main_pend),
    .hit_o(main_hit), .cur_o(main_cur)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clk_en_q <= 1'b0;
    else         clk_en_q <= main_hit;
  end

  assign clk_en_o = clk_en_q;
endmodule

// File: rtl/frac_clk_div_chk.sv
module frac_clk_div_chk #(
  parameter int FIELD_W = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               enable_i,
  input logic               clk_en_o,
  input logic               main_busy,
  input logic               pre_busy,
  input logic               pre_tick,
  input logic [FIELD_W-1:0] main_cur
);
  AST_OFF_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !clk_en_o); // R7
  AST_OFF_NO_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !main_busy) |=> !main_busy); // R6
  AST_MAIN_CLEAR_AT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(main_busy) |-> clk_en_o); // R5
  AST_DIV_SWAP_AT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(main_cur) |-> clk_en_o); // R5
  AST_PRE_CLEAR_AT_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pre_busy) |-> $past(pre_tick)); // R8
endmodule

bind frac_clk_div frac_clk_div_chk #(.FIELD_W(INT_W + FRAC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .clk_en_o(clk_en_o),
  .main_busy(main_busy), .pre_busy(pre_busy), .pre_tick(pre_tick),
  .main_cur(main_cur)
);

// File: tb/frac_clk_div_tb.sv
module frac_clk_div_tb;
  typedef struct packed {
    logic [11:0] v;
    logic [3:0]  pre;
    logic [9:0]  gmin;
    logic [9:0]  gmax;
  } vec_t;

  localparam int NV = 9;
  // main field, pre field, gap floor, gap ceiling
  localparam vec_t VECS [NV] = '{
    '{12'd0,   4'd0, 10'd1,   10'd1},
    '{12'd8,   4'd0, 10'd1,   10'd2},
    '{12'd16,  4'd0, 10'd2,   10'd2},
    '{12'd40,  4'd0, 10'd3,   10'd4},
    '{12'd37,  4'd0, 10'd3,   10'd4},
    '{12'hFF0, 4'd0, 10'd256, 10'd256},
    '{12'hFFF, 4'd0, 10'd256, 10'd257},
    '{12'd16,  4'd1, 10'd4,   10'd4},
    '{12'd8,   4'd2, 10'd3,   10'd6}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic enable_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = 2'd0;
  logic [31:0] wr_data_i = '0;
  logic [1:0] rd_addr_i = 2'd0;
  logic [31:0] rd_data_o;
  logic clk_en_o;
  int checks = 0;
  int fails = 0;

  always #10 clk_i = ~clk_i;

  frac_clk_div u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .clk_en_o(clk_en_o)
  );

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_rng(string req, string what, longint act, longint lo, longint hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic apply(int v, int pre);
    int n;
    wr(2'd0, 32'(v) << 4);
    wr(2'd1, 32'(pre));
    rd_addr_i = 2'd2;
    wr(2'd2, 32'h3);
    n = 0;
    while (rd_data_o[1:0] != 2'b00 && n < 10000) begin tick(); n++; end
    chk("R4", "trigger bits cleared", rd_data_o[1:0], 0);
  endtask

  task automatic measure(int v, int pre, int gmin, int gmax, string req);
    int waited, gap, total;
    waited = 0; total = 0;
    while (!clk_en_o && waited < 5000) begin tick(); waited++; end
    chk(req, "pulse seen", clk_en_o, 1);
    for (int k = 0; k < 16; k++) begin
      gap = 0;
      do begin tick(); gap++; end while (!clk_en_o && gap < 5000);
      chk_rng("R3", "gap", gap, gmin, gmax);
      total += gap;
    end
    chk("R2", "16-period span", total, (v + 16) * (pre + 1));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int quiet, n;
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    // R9 reset state
    for (int a = 0; a < 3; a++) begin
      rd_addr_i = 2'(a);
      #1 chk("R9", "reset read", rd_data_o, 0);
    end
    // R7 silent while disabled
    quiet = 0;
    for (int i = 0; i < 20; i++) begin tick(); quiet += int'(clk_en_o); end
    chk("R7", "pulses while disabled", quiet, 0);
    // R1 field placement
    wr(2'd0, 32'hFFFF_FFFF);
    rd_addr_i = 2'd0; #1 chk("R1", "main field readback", rd_data_o, 32'h0000_FFF0);
    wr(2'd1, 32'hFFFF_FFFF);
    rd_addr_i = 2'd1; #1 chk("R1", "pre field readback", rd_data_o, 32'h0000_000F);
    wr(2'd1, 32'h0);
    // R6 trigger ignored while disabled
    wr(2'd0, 32'd16 << 4);
    rd_addr_i = 2'd2;
    wr(2'd2, 32'h3);
    chk("R6", "trigger while disabled", rd_data_o[1:0], 0);
    enable_i = 1'b1;
    tick();
    chk("R6", "trigger stays 0 after enable", rd_data_o[1:0], 0);
    measure(0, 0, 1, 1, "R9"); // old divide-by-1 still active (R6)
    // table of divisors
    for (int i = 0; i < NV; i++) begin
      apply(int'(VECS[i].v), int'(VECS[i].pre));
      measure(int'(VECS[i].v), int'(VECS[i].pre), int'(VECS[i].gmin),
              int'(VECS[i].gmax), (VECS[i].pre != 0) ? "R8" : "R3");
    end
    // R5 commit against a long period: clears with the boundary pulse
    apply(12'hFFF, 0);
    measure(12'hFFF, 0, 256, 257, "R5");
    wr(2'd0, 32'h0);
    rd_addr_i = 2'd2;
    wr(2'd2, 32'h1);
    chk("R4", "trigger reads 1 after commit", rd_data_o[0], 1);
    n = 0;
    while (rd_data_o[0] && n < 1000) begin tick(); n++; end
    chk("R5", "pulse in clearing cycle", clk_en_o, 1);
    chk_rng("R5", "cycles to boundary", n, 0, 257);
    measure(0, 0, 1, 1, "R5");
    // R7 disable stops output
    enable_i = 1'b0;
    tick();
    quiet = 0;
    for (int i = 0; i < 10; i++) begin tick(); quiet += int'(clk_en_o); end
    chk("R7", "pulses after disable", quiet, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule